// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control path of a single-thread register-rename stage. It takes at most one instruction per cycle from decode and forwards it downstream. It decides, cycle by cycle, whether the stage runs, blocks, drains held work, waits on a barrier or is squashed. It reads the free-entry counts of the reorder buffer (ROB), the issue queue (IQ) and the load/store queue (LSQ). It also reads a ROB-empty flag, stall requests from execute and commit, a squash request, and two serialization flags carried by each instruction. Register mapping is not part of this block.

Decode keeps delivering for a few cycles after it is told to block. A skid buffer catches those instructions, and it holds MAX_WIDTH times DEC_DELAY entries. The stage keeps its own count of instructions already sent downstream whose arrival is not yet reflected in the free counts. The downstream side reports each such arrival with `sent_ack`, and the count is subtracted from every free count before the stage checks for room.

Top module: `rename_ctl`

## Requirements
- R1: The `state` port uses this encoding: Running=0, Idle=1, StartSquash=2, Squashing=3, Blocked=4, Unblocking=5, SerializeStall=6. After reset the state is Idle, and `out_valid`, `block_to_dec` and `squash_vld` are low.
- R2: In Idle with no valid decode input and an empty skid buffer, the stage stays Idle. A valid decode input moves it to Running. The instruction appears on `out_valid`/`out_tag` one cycle after it is presented.
- R3: When nothing stalls, the stage forwards instructions one per cycle, in arrival order, with one cycle of latency.
- R4: A stall request from execute or commit moves the stage to Blocked. In Blocked, `block_to_dec` is high, nothing is forwarded, and arriving decode instructions go into the skid buffer.
- R5: When the stall clears, Blocked moves to Unblocking. Unblocking forwards held instructions oldest first, ahead of any new decode input, which also queues behind them. The stage returns to Running only in the cycle its skid buffer becomes empty.
- R6: `full_src` names the first exhausted structure, in priority ROB (0), then IQ (1), then LSQ (2), and reads NONE (3) when all three have room. A pending instruction facing any exhausted structure blocks the stage.
- R7: A structure counts as exhausted when its reported free count is no greater than the number of instructions in flight. That number rises by one per forwarded instruction and falls by one per `sent_ack`, and it never drops below zero.
- R8: An instruction flagged serialize-before is held in SerializeStall, with `block_to_dec` high, until `rob_empty` is high and the in-flight count is zero. It is then forwarded with `out_serial` high.
- R9: Forwarding an instruction flagged serialize-after makes the next forwarded instruction serializing, as in R8, even if that instruction has not arrived yet.
- R10: A squash request moves the stage to StartSquash, then Squashing, then Idle. It discards the skid buffer, the decode input of that cycle and the in-flight count. While in StartSquash, `squash_vld` is high and `squash_cnt` equals the number of discarded instructions.
- R11: The skid buffer holds MAX_WIDTH*DEC_DELAY instructions and never loses one that arrived while it had room. A push into a full buffer is an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_tag | input | TAG_W | Instruction identifier |
| dec_ser_before | input | 1 | Instruction must wait for an empty back end |
| dec_ser_after | input | 1 | Instruction makes its successor serializing |
| rob_free | input | CNT_W | Free ROB entries as last reported |
| iq_free | input | CNT_W | Free IQ entries as last reported |
| lsq_free | input | CNT_W | Free LSQ entries as last reported |
| rob_empty | input | 1 | ROB holds nothing |
| exe_stall | input | 1 | Execute requests a stall |
| cmt_stall | input | 1 | Commit requests a stall |
| sent_ack | input | 1 | One forwarded instruction is now reflected in the free counts |
| squash_req | input | 1 | Discard everything held |
| out_valid | output | 1 | An instruction is forwarded |
| out_tag | output | TAG_W | Tag of the forwarded instruction |
| out_serial | output | 1 | Forwarded instruction was serializing |
| block_to_dec | output | 1 | Tells decode to stop |
| full_src | output | 2 | First exhausted structure (ROB/IQ/LSQ/NONE) |
| state | output | 3 | Controller state |
| squash_vld | output | 1 | `squash_cnt` is valid |
| squash_cnt | output | CNT_W | Instructions discarded by the squash |

## Verification
The bench builds the block with MAX_WIDTH=2 and DEC_DELAY=2, which gives a four-entry skid buffer. Four stalled arrivals then fill the buffer exactly, and a fifth arrival during draining shows that held work goes first while the buffer refills. A ROB free count of 2 lets in-flight accounting exhaust the ROB after two forwarded instructions. Manual acknowledgements then release the stage one step at a time.

// File: rtl/rn_pkg.sv
package rn_pkg;

    typedef enum logic [2:0] {
        RS_RUN      = 3'd0,
        RS_IDLE     = 3'd1,
        RS_SQ_START = 3'd2,
        RS_SQ_BUSY  = 3'd3,
        RS_BLOCK    = 3'd4,
        RS_UNBLOCK  = 3'd5,
        RS_SER_WAIT = 3'd6
    } rn_state_e;

    typedef enum logic [1:0] {
        FS_ROB  = 2'd0,
        FS_IQ   = 2'd1,
        FS_LSQ  = 2'd2,
        FS_NONE = 2'd3
    } full_src_e;

endpackage

// File: rtl/rn_skid_fifo.sv
module rn_skid_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 10,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];
    logic [PW-1:0] rd_d, rd_q, wr_d, wr_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign count = cnt_q;
    assign dout  = mem_q[rd_q];

    always_comb begin
        mem_d   = mem_q;
        rd_d    = rd_q;
        wr_d    = wr_q;
        cnt_d   = cnt_q;
        do_pop  = pop && !empty && !clr;
        do_push = push && !clr && (!full || do_pop);
        if (clr) begin
            rd_d  = '0;
            wr_d  = '0;
            cnt_d = '0;
        end else begin
            if (do_pop) begin
                rd_d = ptr_inc(rd_q);
            end
            if (do_push) begin
                mem_d[wr_q] = din;
                wr_d        = ptr_inc(wr_q);
            end
            cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            rd_q  <= rd_d;
            wr_q  <= wr_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/rn_room_check.sv
module rn_room_check
    import rn_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] rob_free,
    input  logic [CNT_W-1:0] iq_free,
    input  logic [CNT_W-1:0] lsq_free,
    input  logic [CNT_W-1:0] inflight,
    output full_src_e        src
);
    localparam int NRES = 3;

    logic [CNT_W-1:0] raw  [NRES];
    logic [NRES-1:0]  gone;

    assign raw[0] = rob_free;
    assign raw[1] = iq_free;
    assign raw[2] = lsq_free;

    for (genvar i = 0; i < NRES; i++) begin : g_res
        assign gone[i] = (raw[i] <= inflight);
    end

    always_comb begin
        if (gone[0])      src = FS_ROB;
        else if (gone[1]) src = FS_IQ;
        else if (gone[2]) src = FS_LSQ;
        else              src = FS_NONE;
    end

endmodule

// File: rtl/rename_ctl.sv
module rename_ctl
    import rn_pkg::*;
#(
    parameter int MAX_WIDTH = 2,
    parameter int DEC_DELAY = 2,
    parameter int TAG_W     = 8,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [TAG_W-1:0] dec_tag,
    input  logic             dec_ser_before,
    input  logic             dec_ser_after,
    input  logic [CNT_W-1:0] rob_free,
    input  logic [CNT_W-1:0] iq_free,
    input  logic [CNT_W-1:0] lsq_free,
    input  logic             rob_empty,
    input  logic             exe_stall,
    input  logic             cmt_stall,
    input  logic             sent_ack,
    input  logic             squash_req,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             out_serial,
    output logic             block_to_dec,
    output logic [1:0]       full_src,
    output logic [2:0]       state,
    output logic             squash_vld,
    output logic [CNT_W-1:0] squash_cnt
);
    localparam int SKID_DEPTH = MAX_WIDTH * DEC_DELAY;
    localparam int SCW        = $clog2(SKID_DEPTH + 1);
    localparam int DW         = TAG_W + 2;

    typedef struct packed {
        rn_state_e        state;
        logic [CNT_W-1:0] inflight;
        logic             pending;
        logic             out_valid;
        logic [TAG_W-1:0] out_tag;
        logic             out_serial;
        logic             sq_vld;
        logic [CNT_W-1:0] sq_cnt;
    } ctl_t;

    ctl_t d, q;

    logic             skid_push, skid_pop, skid_clr, skid_empty, skid_full;
    logic [SCW-1:0]   skid_cnt, skid_next;
    logic [DW-1:0]    skid_dout;
    full_src_e        fsrc;
    logic             cand_vld, cand_from_skid, cand_sb, cand_sa, cand_ser;
    logic [TAG_W-1:0] cand_tag;
    logic             ext_stall, res_stall, ser_wait, active, issue;
    logic [CNT_W-1:0] infl_tmp;

    rn_skid_fifo #(.DEPTH(SKID_DEPTH), .DW(DW), .CW(SCW)) u_skid (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (skid_clr),
        .push  (skid_push),
        .pop   (skid_pop),
        .din   ({dec_ser_before, dec_ser_after, dec_tag}),
        .dout  (skid_dout),
        .count (skid_cnt),
        .empty (skid_empty),
        .full  (skid_full)
    );

    rn_room_check #(.CNT_W(CNT_W)) u_room (
        .rob_free (rob_free),
        .iq_free  (iq_free),
        .lsq_free (lsq_free),
        .inflight (q.inflight),
        .src      (fsrc)
    );

    always_comb begin
        d            = q;
        d.out_valid  = 1'b0;
        d.out_serial = 1'b0;
        d.sq_vld     = 1'b0;

        cand_from_skid = !skid_empty;
        cand_vld       = cand_from_skid || dec_valid;
        {cand_sb, cand_sa, cand_tag} = cand_from_skid ? skid_dout
                                     : {dec_ser_before, dec_ser_after, dec_tag};
        ext_stall = exe_stall || cmt_stall;
        res_stall = cand_vld && (fsrc != FS_NONE);
        cand_ser  = cand_sb || q.pending;
        ser_wait  = cand_vld && cand_ser && !(rob_empty && (q.inflight == '0));
        active    = (q.state == RS_RUN) || (q.state == RS_IDLE) ||
                    (q.state == RS_UNBLOCK) || (q.state == RS_SER_WAIT);
        issue     = active && cand_vld && !ext_stall && !res_stall && !ser_wait;
        skid_clr  = 1'b0;

        if (squash_req || (q.state == RS_SQ_START) || (q.state == RS_SQ_BUSY)) begin
            issue = 1'b0;
        end
        skid_pop  = issue && cand_from_skid;
        skid_push = dec_valid && !(issue && !cand_from_skid);

        infl_tmp = q.inflight + CNT_W'(issue);
        if (sent_ack && (infl_tmp != '0)) begin
            infl_tmp = infl_tmp - 1'b1;
        end
        d.inflight = infl_tmp;

        if (issue) begin
            d.out_valid  = 1'b1;
            d.out_tag    = cand_tag;
            d.out_serial = cand_ser;
            d.pending    = cand_sa;
        end

        if (squash_req) begin
            skid_push  = 1'b0;
            skid_clr   = 1'b1;
            d.state    = RS_SQ_START;
            d.sq_vld   = 1'b1;
            d.sq_cnt   = CNT_W'(skid_cnt) + CNT_W'(dec_valid);
            d.pending  = 1'b0;
            d.inflight = '0;
        end else if (q.state == RS_SQ_START) begin
            skid_push = 1'b0;
            d.state   = RS_SQ_BUSY;
        end else if (q.state == RS_SQ_BUSY) begin
            skid_push = 1'b0;
            d.state   = RS_IDLE;
        end else begin
            if (ext_stall || res_stall)             d.state = RS_BLOCK;
            else if (q.state == RS_BLOCK)           d.state = RS_UNBLOCK;
            else if (ser_wait)                      d.state = RS_SER_WAIT;
            else if (skid_next != '0)               d.state = RS_UNBLOCK;
            else if (q.state == RS_IDLE && !dec_valid) d.state = RS_IDLE;
            else                                    d.state = RS_RUN;
        end
    end

    always_comb begin
        skid_next = skid_cnt;
        if (skid_clr) begin
            skid_next = '0;
        end else begin
            if (skid_pop) skid_next = skid_next - 1'b1;
            if (skid_push && (!skid_full || skid_pop)) skid_next = skid_next + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.state    <= RS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign out_valid    = q.out_valid;
    assign out_tag      = q.out_tag;
    assign out_serial   = q.out_serial;
    assign block_to_dec = (q.state == RS_BLOCK) || (q.state == RS_UNBLOCK) ||
                          (q.state == RS_SER_WAIT);
    assign full_src     = fsrc;
    assign state        = q.state;
    assign squash_vld   = q.sq_vld;
    assign squash_cnt   = q.sq_cnt;

endmodule

// File: rtl/rename_ctl_chk.sv
module rename_ctl_chk
    import rn_pkg::*;
#(
    parameter int SCW   = 3,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       state,
    input logic             block_to_dec,
    input logic             out_valid,
    input logic             out_serial,
    input logic             squash_req,
    input logic             rob_empty,
    input logic [CNT_W-1:0] inflight,
    input logic [CNT_W-1:0] rob_free,
    input logic [1:0]       full_src,
    input logic [SCW-1:0]   skid_cnt,
    input logic             skid_push,
    input logic             skid_pop,
    input logic             skid_full
);
    a_r4_block_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_BLOCK) |-> block_to_dec);

    a_r4_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_BLOCK) |=> !out_valid);

    a_r10_enter_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash_req |=> (state == RS_SQ_START));

    a_r10_squash_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_SQ_START && !squash_req) |=> (state == RS_SQ_BUSY));

    a_r5_run_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RS_RUN && $past(state) == RS_UNBLOCK) |-> (skid_cnt == '0));

    a_r8_serial_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_serial) |-> ($past(rob_empty) && $past(inflight) == '0));

    a_r6_rob_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_free <= inflight) |-> (full_src == FS_ROB));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (skid_push && skid_full) |-> skid_pop);

endmodule

bind rename_ctl rename_ctl_chk #(.SCW(SCW), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .block_to_dec (block_to_dec),
    .out_valid    (out_valid),
    .out_serial   (out_serial),
    .squash_req   (squash_req),
    .rob_empty    (rob_empty),
    .inflight     (q.inflight),
    .rob_free     (rob_free),
    .full_src     (full_src),
    .skid_cnt     (skid_cnt),
    .skid_push    (skid_push),
    .skid_pop     (skid_pop),
    .skid_full    (skid_full)
);

// File: tb/rename_ctl_test.sv
`timescale 1ns/1ps
module rename_ctl_test;
    import rn_pkg::*;

    localparam int TAG_W = 8;
    localparam int CNT_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dec_valid = 1'b0;
    logic [TAG_W-1:0] dec_tag = '0;
    logic             dec_ser_before = 1'b0;
    logic             dec_ser_after = 1'b0;
    logic [CNT_W-1:0] rob_free = 6'd8, iq_free = 6'd8, lsq_free = 6'd8;
    logic             rob_empty = 1'b1;
    logic             exe_stall = 1'b0, cmt_stall = 1'b0;
    logic             squash_req = 1'b0;
    logic             ack_en = 1'b1, man_ack = 1'b0;
    logic             sent_ack;
    logic             out_valid, out_serial, block_to_dec, squash_vld;
    logic [TAG_W-1:0] out_tag;
    logic [1:0]       full_src;
    logic [2:0]       state;
    logic [CNT_W-1:0] squash_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [TAG_W-1:0] exp_q [$];

    always #2 clk = ~clk;

    assign sent_ack = ack_en ? out_valid : man_ack;

    rename_ctl #(.MAX_WIDTH(2), .DEC_DELAY(2), .TAG_W(TAG_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_tag(dec_tag),
        .dec_ser_before(dec_ser_before), .dec_ser_after(dec_ser_after),
        .rob_free(rob_free), .iq_free(iq_free), .lsq_free(lsq_free),
        .rob_empty(rob_empty), .exe_stall(exe_stall), .cmt_stall(cmt_stall),
        .sent_ack(sent_ack), .squash_req(squash_req), .out_valid(out_valid),
        .out_tag(out_tag), .out_serial(out_serial), .block_to_dec(block_to_dec),
        .full_src(full_src), .state(state), .squash_vld(squash_vld),
        .squash_cnt(squash_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic put(input int t, input bit sb, input bit sa, input bit expect_out);
        dec_valid      = 1'b1;
        dec_tag        = TAG_W'(t);
        dec_ser_before = sb;
        dec_ser_after  = sa;
        if (expect_out) exp_q.push_back(TAG_W'(t));
    endtask

    task automatic idle_in();
        dec_valid      = 1'b0;
        dec_ser_before = 1'b0;
        dec_ser_after  = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // scoreboard monitor: R3 order check
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R3 unexpected tag act=%0d exp=none", out_tag);
            end else begin
                chk("R3 order", out_tag, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 state", state, RS_IDLE);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 block", block_to_dec, 0);
        chk("R1 squash_vld", squash_vld, 0);
        cyc(); cyc();
        chk("R2 idle holds", state, RS_IDLE);

        // R2/R3 first input then a stream
        put(1, 0, 0, 1);
        cyc();
        chk("R2 running", state, RS_RUN);
        chk("R2 out_valid", out_valid, 1);
        for (int i = 2; i <= 5; i++) begin
            put(i, 0, 0, 1);
            cyc();
        end
        idle_in();
        cyc(); cyc();
        chk("R3 drained", exp_q.size(), 0);

        // R4/R5/R11 stall fills the skid buffer
        exe_stall = 1'b1;
        put(10, 0, 0, 1);
        cyc();
        chk("R4 blocked", state, RS_BLOCK);
        chk("R4 block_to_dec", block_to_dec, 1);
        for (int i = 11; i <= 13; i++) begin
            put(i, 0, 0, 1);
            cyc();
            chk("R4 no output", out_valid, 0);
        end
        idle_in();
        exe_stall = 1'b0;
        cyc();
        chk("R5 unblocking", state, RS_UNBLOCK);
        put(14, 0, 0, 1);
        cyc();
        idle_in();
        chk("R5 drain first", out_tag, 10);
        cyc(); cyc(); cyc();
        chk("R5 still unblocking", state, RS_UNBLOCK);
        cyc();
        chk("R5 running after drain", state, RS_RUN);
        cyc();
        chk("R11 all held items out", exp_q.size(), 0);

        // commit stall also blocks (R4)
        cmt_stall = 1'b1;
        cyc();
        chk("R4 commit stall", state, RS_BLOCK);
        cmt_stall = 1'b0;
        cyc(); cyc();
        chk("R5 empty unblock", state, RS_RUN);

        // R6 priority, encoding ROB=0 IQ=1 LSQ=2 NONE=3
        rob_free = 0; iq_free = 0; lsq_free = 0;
        #1 chk("R6 rob first", full_src, 0);
        rob_free = 8;
        #1 chk("R6 iq next", full_src, 1);
        iq_free = 8;
        #1 chk("R6 lsq last", full_src, 2);
        lsq_free = 8;
        #1 chk("R6 none", full_src, 3);
        cyc();

        // R7 in-flight subtraction
        ack_en = 1'b0;
        rob_free = 2;
        put(20, 0, 0, 1);
        cyc();
        put(21, 0, 0, 1);
        cyc();
        put(22, 0, 0, 1);
        cyc();
        chk("R7 blocked by inflight", state, RS_BLOCK);
        chk("R7 source rob", full_src, 0);
        idle_in();
        man_ack = 1'b1;
        cyc();
        cyc();
        chk("R7 released", state, RS_UNBLOCK);
        man_ack = 1'b0;
        cyc();
        ack_en = 1'b1;
        cyc();
        chk("R7 held tag out", out_tag, 22);
        ack_en = 1'b0; man_ack = 1'b1;
        cyc(); cyc();
        man_ack = 1'b0; ack_en = 1'b1;
        rob_free = 8;

        // R8 serialize-before
        rob_empty = 1'b0;
        put(30, 1, 0, 1);
        cyc();
        idle_in();
        chk("R8 waiting", state, RS_SER_WAIT);
        chk("R8 block", block_to_dec, 1);
        chk("R8 no output", out_valid, 0);
        cyc();
        chk("R8 still waiting", state, RS_SER_WAIT);
        rob_empty = 1'b1;
        cyc();
        chk("R8 issued", out_valid, 1);
        chk("R8 serial flag", out_serial, 1);
        cyc();

        // R9 serialize-after
        put(40, 0, 1, 1);
        cyc();
        chk("R9 first not serial", out_serial, 0);
        rob_empty = 1'b0;
        put(41, 0, 0, 1);
        cyc();
        idle_in();
        chk("R9 successor waits", state, RS_SER_WAIT);
        rob_empty = 1'b1;
        cyc();
        chk("R9 successor out", out_tag, 41);
        chk("R9 successor serial", out_serial, 1);
        cyc();

        // R10 squash
        exe_stall = 1'b1;
        put(50, 0, 0, 0);
        cyc();
        put(51, 0, 0, 0);
        cyc();
        put(52, 0, 0, 0);
        squash_req = 1'b1;
        cyc();
        squash_req = 1'b0; exe_stall = 1'b0;
        idle_in();
        chk("R10 start", state, RS_SQ_START);
        chk("R10 squash_vld", squash_vld, 1);
        chk("R10 count", squash_cnt, 3);
        cyc();
        chk("R10 squashing", state, RS_SQ_BUSY);
        cyc();
        chk("R10 idle", state, RS_IDLE);
        chk("R10 block low", block_to_dec, 0);
        cyc();
        chk("R2 idle after squash", state, RS_IDLE);
        put(60, 0, 0, 1);
        cyc();
        idle_in();
        chk("R2 resumes", state, RS_RUN);
        cyc(); cyc();
        chk("R10 nothing left", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule